// File: doc/BRIEF.md
# Serial Input Expander Read Controller

This block is the host-side sequencer for one or more cascaded parallel-load, serial-out shift registers used to widen a chip's input count. When `start` is seen while idle, it strobes the active-low `load_n` line so the external registers capture their parallel inputs. It then asserts the active-low `enable_n`, keeps `shift_clk` low for one phase, and issues a runtime-chosen number of clock pulses. Each bit of `ser_in` is taken just before a rising clock edge and shifted into an accumulator, most significant first. It then releases `enable_n` and presents the assembled word, right-aligned, with a one-cycle `done` pulse.

Every phase lasts `phase_div + 2` system clock cycles, written P below. The serial line passes through a two-flop synchronizer. That is why a phase can never be shorter than two cycles. The bit count can be any value from 1 to 31, so a single 8-bit device, two cascaded devices (16 bits) or a partly used device (for example 6 bits) is read with no wasted pulses. When `keep_enable` is high, `enable_n` stays low at all times. This is for boards where the enable pin is tied active.

The sequencer states are IDLE, LOAD_LO, LOAD_HI, PREP, CLK_HI, CLK_LO and FINISH. The transitions are:
- IDLE→LOAD_LO when start is accepted.
- LOAD_LO→LOAD_HI, LOAD_HI→PREP and PREP→CLK_HI at each phase end. The PREP→CLK_HI transition captures a bit.
- CLK_HI→CLK_LO at phase end.
- CLK_LO→CLK_HI at phase end when bits remain. This transition captures a bit.
- CLK_LO→FINISH at phase end on the last bit.
- FINISH→IDLE always.

Top module: `sie_read_ctrl`

## Requirements
- R1: In reset and afterwards while idle with `keep_enable` low, the outputs are: `load_n`=1, `shift_clk`=0, `enable_n`=1, `busy`=0, `done`=0 and `result`=0.
- R2: A start accepted on an idle clock edge drives `load_n` low for exactly P cycles, beginning in the next cycle, where P = `phase_div`+2. `load_n` then stays high for P cycles before any clock pulse.
- R3: After the load strobe, `enable_n` goes low (with `shift_clk` low) for one phase before the first rising clock. `enable_n` stays low until the last low clock phase ends.
- R4: Exactly N clock pulses are produced, where N = `bit_count`. Each pulse is high for P cycles and then low for P cycles, and `shift_clk` is never high while `load_n` is low.
- R5: The synchronized `ser_in` is sampled on the last cycle before each rising clock. The first sample becomes the most significant of the N result bits. `result` holds the N bits in bits N-1..0, and its upper bits are zero.
- R6: After the last low phase, the block spends one cycle in FINISH with `done`=1, `enable_n` released and `result` updated. `busy` is high for exactly (2N+3)·P+1 cycles.
- R7: A start while busy, including during FINISH, is ignored. A start with `bit_count`=0 is ignored and `busy` stays low.
- R8: `bit_count` and `phase_div` are captured when start is accepted. Changing them during a transfer does not change its timing or its result.
- R9: With `keep_enable`=1, `enable_n` is 0 in every cycle, and the load, clock and data timing are unchanged.
- R10: `result` keeps its value from one FINISH until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a read (ignored while busy) |
| bit_count | input | 5 | Number of bits to read, 1 to 31 |
| phase_div | input | 8 | Phase length minus two, in clock cycles |
| keep_enable | input | 1 | Hold the device enable asserted permanently |
| ser_in | input | 1 | Serial data from the last register in the chain |
| load_n | output | 1 | Active-low parallel load strobe |
| shift_clk | output | 1 | Shift clock to the registers |
| enable_n | output | 1 | Active-low device enable |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 32 | Assembled word, right-aligned |

## Verification
Reads are run against a behavioural model of a 32-bit chained device. The patterns cover one device (8 bits, with the 0x82 pattern placed in the top byte), two cascaded devices (16 bits), a partial 6-bit read, and the 1-bit and 31-bit extremes. These show whether the bit count, the MSB-first order and right alignment are honoured. Alternating and walking data patterns expose a sample taken one phase early or late. Several phase lengths separate a fixed-latency design from one that follows `phase_div`. Starts issued mid-transfer with altered count and divider, a zero-count start, and a read with the enable held show whether inputs are latched and starts are ignored as required.

// File: rtl/sie_pkg.sv
package sie_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_LO,
        ST_LOAD_HI,
        ST_PREP,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_FINISH
    } sie_state_e;

endpackage

// File: rtl/sie_sync.sv
module sie_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/sie_phase_timer.sv
module sie_phase_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          phase_end
);
    localparam logic [CW-1:0] STEP = 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else            cnt_q <= cnt_q + STEP;
    end

    assign phase_end = (cnt_q == limit);

    // R2: the phase counter never runs past the latched limit
    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

endmodule

// File: rtl/sie_accum.sv
module sie_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         capture,
    output logic [W-1:0] result
);
    logic [W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc_q <= '0;
        else if (clear)    acc_q <= '0;
        else if (shift_en) acc_q <= {acc_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       result <= '0;
        else if (capture) result <= acc_q;
    end

    // R10: the reported word only moves on a capture
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(result));

endmodule

// File: rtl/sie_read_ctrl.sv
module sie_read_ctrl
    import sie_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int PHASE_W     = 8,
    parameter int RES_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   bit_count,
    input  logic [PHASE_W-1:0] phase_div,
    input  logic               keep_enable,
    input  logic               ser_in,
    output logic               load_n,
    output logic               shift_clk,
    output logic               enable_n,
    output logic               busy,
    output logic               done,
    output logic [RES_W-1:0]   result
);
    localparam int              TW      = PHASE_W + 1;
    localparam logic [TW-1:0]   LIM_ADD = 1;
    localparam logic [CNT_W-1:0] ONE_BIT = 1;

    sie_state_e        state_q, state_nxt;
    logic [PHASE_W-1:0] div_q;
    logic [CNT_W-1:0]   bits_q;
    logic [TW-1:0]      limit;
    logic               phase_end;
    logic               timer_clear;
    logic               ser_sync;
    logic               take_bit;
    logic               acc_clear;
    logic               capture;
    logic               accept;

    assign accept = (state_q == ST_IDLE) && start && (bit_count != '0);
    assign limit  = {1'b0, div_q} + LIM_ADD;

    sie_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ser_in),
        .d_out (ser_sync)
    );

    sie_phase_timer #(.CW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .limit     (limit),
        .phase_end (phase_end)
    );

    sie_accum #(.W(RES_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (acc_clear),
        .shift_en (take_bit),
        .bit_in   (ser_sync),
        .capture  (capture),
        .result   (result)
    );

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)    state_nxt = ST_LOAD_LO;
            ST_LOAD_LO: if (phase_end) state_nxt = ST_LOAD_HI;
            ST_LOAD_HI: if (phase_end) state_nxt = ST_PREP;
            ST_PREP:    if (phase_end) state_nxt = ST_CLK_HI;
            ST_CLK_HI:  if (phase_end) state_nxt = ST_CLK_LO;
            ST_CLK_LO:  if (phase_end) state_nxt = (bits_q == ONE_BIT) ? ST_FINISH : ST_CLK_HI;
            ST_FINISH:                 state_nxt = ST_IDLE;
            default:                   state_nxt = ST_IDLE;
        endcase
    end

    // state register and latched request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            bits_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (accept) begin
                div_q  <= phase_div;
                bits_q <= bit_count;
            end else if (state_q == ST_CLK_LO && phase_end) begin
                bits_q <= bits_q - ONE_BIT;
            end
        end
    end

    // outputs and datapath controls
    always_comb begin
        load_n      = 1'b1;
        shift_clk   = 1'b0;
        enable_n    = 1'b1;
        busy        = 1'b1;
        done        = 1'b0;
        timer_clear = phase_end;
        take_bit    = 1'b0;
        acc_clear   = 1'b0;
        capture     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy        = 1'b0;
                timer_clear = 1'b1;
                acc_clear   = 1'b1;
            end
            ST_LOAD_LO: load_n = 1'b0;
            ST_LOAD_HI: ;
            ST_PREP: begin
                enable_n = 1'b0;
                take_bit = phase_end;
            end
            ST_CLK_HI: begin
                enable_n  = 1'b0;
                shift_clk = 1'b1;
            end
            ST_CLK_LO: begin
                enable_n = 1'b0;
                take_bit = phase_end && (bits_q != ONE_BIT);
                capture  = phase_end && (bits_q == ONE_BIT);
            end
            ST_FINISH: begin
                done        = 1'b1;
                timer_clear = 1'b1;
            end
            default: busy = 1'b0;
        endcase
        if (keep_enable) enable_n = 1'b0;
    end

    // R4: clocking and loading never overlap
    p_no_clock_in_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |-> load_n);

    // R3: the device is enabled whenever it is clocked
    p_enabled_when_clocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_clk |-> !enable_n);

    // R5: every rising clock follows a bit capture
    p_sample_before_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> $past(take_bit));

    // R6: done lasts one cycle and ends the transfer
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R7: a transfer is never cut short by a new start
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

endmodule

// File: tb/test_sie_read_ctrl.sv
module test_sie_read_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  bit_count = '0;
    logic [7:0]  phase_div = '0;
    logic        keep_enable = 1'b0;
    logic        ser_in;
    logic        load_n, shift_clk, enable_n, busy, done;
    logic [31:0] result;

    always #5 clk = ~clk;

    sie_read_ctrl i_sie_read_ctrl (
        .clk (clk), .rst_n (rst_n), .start (start), .bit_count (bit_count),
        .phase_div (phase_div), .keep_enable (keep_enable), .ser_in (ser_in),
        .load_n (load_n), .shift_clk (shift_clk), .enable_n (enable_n),
        .busy (busy), .done (done), .result (result)
    );

    int vectors = 0;
    int miscompares = 0;

    // behavioural 32-bit chained device
    logic [31:0] par = '0;
    logic [31:0] chain = '0;
    logic        clk_prev = 1'b0;
    assign ser_in = chain[31];

    always @(posedge clk) begin
        if (!load_n)                                  chain <= par;
        else if (!enable_n && shift_clk && !clk_prev) chain <= {chain[30:0], 1'b0};
        clk_prev <= shift_clk;
    end

    // reference model: cycle index within the current transfer
    bit          mact = 1'b0;
    int          t = 0, P = 0, N = 0, total = 0;
    logic [31:0] exp_res = '0, pend = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mact    = 1'b0;
            exp_res = '0;
        end else if (mact) begin
            t = t + 1;
            if (t == total - 1) exp_res = pend;
            if (t == total)     mact = 1'b0;
        end else if (start && bit_count != 0) begin
            mact  = 1'b1;
            t     = 0;
            P     = int'(phase_div) + 2;
            N     = int'(bit_count);
            total = (2 * N + 3) * P + 1;
            pend  = par >> (32 - N);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_load, e_clk, e_en, e_done;
            e_load = !(mact && t < P);
            e_clk  = mact && t >= 3 * P && t < 3 * P + 2 * N * P && (((t - 3 * P) / P) % 2 == 0);
            e_en   = keep_enable ? 1'b0 : !(mact && t >= 2 * P && t < 3 * P + 2 * N * P);
            e_done = mact && (t == total - 1);
            check("R2 load_n",   {31'b0, load_n},    {31'b0, e_load});
            check("R4 shift_clk", {31'b0, shift_clk}, {31'b0, e_clk});
            check(keep_enable ? "R9 enable_n" : "R3 enable_n", {31'b0, enable_n}, {31'b0, e_en});
            check("R7 busy",     {31'b0, busy},      {31'b0, mact});
            check("R6 done",     {31'b0, done},      {31'b0, e_done});
            check("R5 R10 result", result, exp_res);
        end
    end

    task automatic wait_done(input string req);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) return;
        end
        check(req, 32'd0, 32'd1);
    endtask

    task automatic xfer(input string req, input int n, input int div,
                        input logic [31:0] data, input bit kp, input bit disturb);
        @(negedge clk); #1;
        par = data; bit_count = 5'(n); phase_div = 8'(div); keep_enable = kp; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            // R7, R8: retrigger with different settings mid-transfer
            repeat (7) @(negedge clk);
            #1;
            bit_count = 5'(n ^ 3); phase_div = 8'(div + 4); start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        wait_done(req);
        check(req, result, data >> (32 - n));
        @(negedge clk); #1;
        check("R6 busy after finish", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        #100000000;
        miscompares++;
        $display("FAIL R6 watchdog expired: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 load_n",    {31'b0, load_n},    32'd1);
        check("R1 shift_clk", {31'b0, shift_clk}, 32'd0);
        check("R1 enable_n",  {31'b0, enable_n},  32'd1);
        check("R1 busy",      {31'b0, busy},      32'd0);
        check("R1 done",      {31'b0, done},      32'd0);
        check("R1 result",    result,             32'd0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        xfer("R5 single device",   8, 0, 32'h8200_0000, 1'b0, 1'b0);
        xfer("R5 cascaded pair",  16, 1, 32'hA5C3_0000, 1'b0, 1'b0);
        xfer("R4 partial read",    6, 0, 32'hB400_0000, 1'b0, 1'b0);
        xfer("R5 widest read",    31, 0, 32'h5555_5555, 1'b0, 1'b0);
        xfer("R4 single bit",      1, 2, 32'h8000_0000, 1'b0, 1'b0);
        xfer("R8 latched inputs", 12, 1, 32'h9F1E_0000, 1'b0, 1'b1);
        xfer("R9 enable held",    10, 3, 32'h4D80_0000, 1'b1, 1'b0);
        xfer("R5 walking ones",   20, 0, 32'h1248_1000, 1'b0, 1'b0);

        // R7: zero-count start is ignored
        @(negedge clk); #1;
        keep_enable = 1'b0; bit_count = 5'd0; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 zero count", {31'b0, busy}, 32'd0);
        // R10: result still holds the previous word
        check("R10 result hold", result, 32'h1248_1000 >> 12);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule